// File: doc/BRIEF.md
# Dynamically Scheduled Integer Core with Reservation Stations

This block is a small out-of-order execution core. It takes register-to-register integer instructions in program order and renames their sources onto reservation stations. Each instruction computes `rd = rs op rt`. When its operands are known, it runs for a fixed number of cycles in its own station. The result then goes out on one shared result bus. Every station that is waiting for that result captures it, and so does the register file when the entry still expects it. There are three station pools: add/subtract, multiply and divide. A tag table records, for each architectural register, which station will produce its next value.

Each station is a small state machine with four states:
- **Free**: empty.
- **Waiting**: holds operands or tags, and snoops the bus for missing operands.
- **Running**: counts the execution latency.
- **Holding**: has a finished result and requests the bus.

The transitions are:
- *allocate*: Free to Waiting, on an accepted issue.
- *launch*: Waiting to Running, when both operands are present.
- *finish*: Running to Holding, in the last execution cycle.
- *retire*: Holding to Free, when the station is granted the bus.

Results go out one at a time. Each one carries the issue, execute-start and execute-end cycle numbers of its instruction, so the timing of every instruction can be checked from outside. A combinational read port exposes the register file.

Top module: `tomasulo_core`

## Requirements
- R1: Opcodes are encoded 0 = add, 1 = sub, 2 = mul, 3 = div. Arithmetic is 32-bit two's complement. Mul keeps the low 32 bits and div truncates toward zero. Add and sub share a pool of 4 stations, mul has 2 stations and div has 3.
- R2: Execution occupies exactly 4 consecutive cycles for add/sub, 12 for mul and 38 for div, as reported by the start and end cycle numbers.
- R3: An instruction whose operands are available when it issues in cycle N starts executing in cycle N+1.
- R4: An instruction waiting on a producer starts executing in the cycle after the producer's writeback. This includes a producer that broadcasts in the consumer's own issue cycle.
- R5: Issue is in order, at most one instruction per cycle. `in_ready` is low while every station of the needed pool is occupied. A station becomes free again in the cycle after its writeback.
- R6: At most one result is broadcast per cycle, no earlier than the cycle after execution ends. When several results are pending, the earliest-issued one goes first and the others wait.
- R7: A register-file entry takes a broadcast value only if its tag still names the broadcasting station. A later writer of the same register therefore keeps its value.
- R8: Division by zero yields 0.
- R9: After reset:
  - register Fi holds the value i;
  - all tags are empty and all stations are free;
  - `wb_valid` is low and `in_ready` is high;
  - the cycle counter reads 1.
- R10: Each broadcast reports the instruction's issue sequence number (0 for the first instruction after reset). `cyc_now` is the current cycle number, and it is 1 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | A station of the needed pool is free; issue happens when both are high |
| in_op | input | 2 | Opcode (0 add, 1 sub, 2 mul, 3 div) |
| in_rd | input | 4 | Destination register |
| in_rs | input | 4 | First source register |
| in_rt | input | 4 | Second source register |
| wb_valid | output | 1 | A result is broadcast this cycle |
| wb_seq | output | 8 | Issue sequence number of the broadcast instruction |
| wb_op | output | 2 | Opcode of the broadcast instruction |
| wb_rd | output | 4 | Destination of the broadcast instruction |
| wb_value | output | 32 | Broadcast result |
| wb_t_issue | output | 16 | Cycle in which the instruction issued |
| wb_t_start | output | 16 | First execution cycle |
| wb_t_end | output | 16 | Last execution cycle |
| cyc_now | output | 16 | Current cycle number |
| rf_addr | input | 4 | Register-file read address |
| rf_data | output | 32 | Register-file read data |

## Verification
An issue shows up combinationally on `in_ready` in the same cycle the instruction is offered. A result is due on the bus in the cycle after its execution ends, plus one cycle for every older result that competes for the bus. The bench's behavioural model works out, for each instruction, its issue, start, end and writeback cycles ahead of time. Half a clock after each rising edge, the bench compares `in_ready` and the whole broadcast with the model's entry for that cycle number. The final register contents are read back through the read port once the last writeback is due.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        POOL_ADDSUB = 2'd0,
        POOL_MUL    = 2'd1,
        POOL_DIV    = 2'd2
    } pool_e;

    function automatic pool_e pool_of_op(op_e op);
        unique case (op)
            OP_ADD, OP_SUB: return POOL_ADDSUB;
            OP_MUL:         return POOL_MUL;
            default:        return POOL_DIV;
        endcase
    endfunction

endpackage

// File: rtl/rs_station.sv
module rs_station
    import tomasulo_pkg::*;
#(
    parameter int LAT    = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int SEQ_W  = 8,
    parameter int CYC_W  = 16,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              alloc_i,
    input  op_e               op_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic              j_rdy_i,
    input  logic [DATA_W-1:0] j_val_i,
    input  logic [TAG_W-1:0]  j_tag_i,
    input  logic              k_rdy_i,
    input  logic [DATA_W-1:0] k_val_i,
    input  logic [TAG_W-1:0]  k_tag_i,
    input  logic              bus_valid_i,
    input  logic [TAG_W-1:0]  bus_tag_i,
    input  logic [DATA_W-1:0] bus_value_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              req_o,
    output op_e               op_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic [RIDX_W-1:0] rd_o,
    output logic [DATA_W-1:0] res_o,
    output logic [CYC_W-1:0]  t_iss_o,
    output logic [CYC_W-1:0]  t_st_o,
    output logic [CYC_W-1:0]  t_end_o
);

    typedef enum logic [1:0] {ST_FREE, ST_WAIT, ST_RUN, ST_HOLD} st_e;

    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

    st_e               state_q, state_d;
    op_e               op_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [RIDX_W-1:0] rd_q;
    logic              j_rdy_q, k_rdy_q;
    logic [DATA_W-1:0] j_val_q, k_val_q, res_q;
    logic [TAG_W-1:0]  j_tag_q, k_tag_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CYC_W-1:0]  t_iss_q, t_st_q, t_end_q;
    logic              go;

    assign go = j_rdy_q && k_rdy_q;

    function automatic logic [DATA_W-1:0] alu(op_e op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
        unique case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return (b == '0) ? '0 : DATA_W'($signed(a) / $signed(b));
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (alloc_i)            state_d = ST_WAIT;
            ST_WAIT: if (go)                 state_d = (LAT == 1) ? ST_HOLD : ST_RUN;
            ST_RUN:  if (cnt_q == LAST)      state_d = ST_HOLD;
            ST_HOLD: if (grant_i)            state_d = ST_FREE;
            default:                         state_d = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // operand capture, execution timing and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            seq_q   <= '0;
            rd_q    <= '0;
            j_rdy_q <= 1'b0;
            k_rdy_q <= 1'b0;
            j_val_q <= '0;
            k_val_q <= '0;
            j_tag_q <= '0;
            k_tag_q <= '0;
            res_q   <= '0;
            cnt_q   <= '0;
            t_iss_q <= '0;
            t_st_q  <= '0;
            t_end_q <= '0;
        end else begin
            if (state_q == ST_FREE && alloc_i) begin
                op_q    <= op_i;
                seq_q   <= seq_i;
                rd_q    <= rd_i;
                j_rdy_q <= j_rdy_i;
                j_val_q <= j_val_i;
                j_tag_q <= j_tag_i;
                k_rdy_q <= k_rdy_i;
                k_val_q <= k_val_i;
                k_tag_q <= k_tag_i;
                t_iss_q <= cyc_i;
            end
            if (state_q == ST_WAIT) begin
                if (go) begin
                    res_q  <= alu(op_q, j_val_q, k_val_q);
                    t_st_q <= cyc_i;
                    cnt_q  <= CNT_W'(1);
                    if (LAT == 1) t_end_q <= cyc_i;
                end else begin
                    if (!j_rdy_q && bus_valid_i && bus_tag_i == j_tag_q) begin
                        j_rdy_q <= 1'b1;
                        j_val_q <= bus_value_i;
                    end
                    if (!k_rdy_q && bus_valid_i && bus_tag_i == k_tag_q) begin
                        k_rdy_q <= 1'b1;
                        k_val_q <= bus_value_i;
                    end
                end
            end
            if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) t_end_q <= cyc_i;
            end
        end
    end

    assign busy_o  = (state_q != ST_FREE);
    assign req_o   = (state_q == ST_HOLD);
    assign op_o    = op_q;
    assign seq_o   = seq_q;
    assign rd_o    = rd_q;
    assign res_o   = res_q;
    assign t_iss_o = t_iss_q;
    assign t_st_o  = t_st_q;
    assign t_end_o = t_end_q;

endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter #(
    parameter int N     = 9,
    parameter int SEQ_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    input  logic [SEQ_W-1:0] seq_i [N],
    output logic             win_valid_o,
    output logic [IDX_W-1:0] win_idx_o
);

    logic [SEQ_W-1:0] best;
    logic [SEQ_W-1:0] diff;

    // earliest issue wins; age compared modulo 2**SEQ_W
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        best        = '0;
        diff        = '0;
        for (int i = 0; i < N; i++) begin
            diff = seq_i[i] - best;
            if (req_i[i] && (!win_valid_o || diff[SEQ_W-1])) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                best        = seq_i[i];
            end
        end
    end

endmodule

// File: rtl/tomasulo_core.sv
module tomasulo_core
    import tomasulo_pkg::*;
#(
    parameter int N_ADD   = 4,
    parameter int N_MUL   = 2,
    parameter int N_DIV   = 3,
    parameter int LAT_ADD = 4,
    parameter int LAT_MUL = 12,
    parameter int LAT_DIV = 38,
    parameter int N_REG   = 13,
    parameter int DATA_W  = 32,
    parameter int SEQ_W   = 8,
    parameter int CYC_W   = 16,
    parameter int RIDX_W  = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [RIDX_W-1:0] in_rd,
    input  logic [RIDX_W-1:0] in_rs,
    input  logic [RIDX_W-1:0] in_rt,
    output logic              wb_valid,
    output logic [SEQ_W-1:0]  wb_seq,
    output logic [1:0]        wb_op,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [DATA_W-1:0] wb_value,
    output logic [CYC_W-1:0]  wb_t_issue,
    output logic [CYC_W-1:0]  wb_t_start,
    output logic [CYC_W-1:0]  wb_t_end,
    output logic [CYC_W-1:0]  cyc_now,
    input  logic [RIDX_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data
);

    localparam int N_RS  = N_ADD + N_MUL + N_DIV;
    localparam int TAG_W = $clog2(N_RS);

    typedef struct packed {
        logic              rdy;
        logic [DATA_W-1:0] val;
        logic [TAG_W-1:0]  tag;
    } src_t;

    function automatic pool_e pool_of_rs(int i);
        if (i < N_ADD)         return POOL_ADDSUB;
        if (i < N_ADD + N_MUL) return POOL_MUL;
        return POOL_DIV;
    endfunction

    logic [DATA_W-1:0] rf [N_REG];
    logic [N_REG-1:0]  stat_v;
    logic [TAG_W-1:0]  stat_tag [N_REG];
    logic [CYC_W-1:0]  cyc_q;
    logic [SEQ_W-1:0]  seq_q;

    logic [N_RS-1:0]   busy, req, alloc, grant;
    op_e               rs_op   [N_RS];
    logic [SEQ_W-1:0]  rs_seq  [N_RS];
    logic [RIDX_W-1:0] rs_rd   [N_RS];
    logic [DATA_W-1:0] rs_res  [N_RS];
    logic [CYC_W-1:0]  rs_tiss [N_RS];
    logic [CYC_W-1:0]  rs_tst  [N_RS];
    logic [CYC_W-1:0]  rs_tend [N_RS];

    logic              win_valid;
    logic [TAG_W-1:0]  win_idx;
    logic [DATA_W-1:0] bus_value;
    logic [RIDX_W-1:0] bus_rd;
    logic              found, accept;
    logic [TAG_W-1:0]  alloc_idx;
    src_t              src_j, src_k;

    assign bus_value = rs_res[win_idx];
    assign bus_rd    = rs_rd[win_idx];

    function automatic src_t lookup(logic [RIDX_W-1:0] r);
        src_t s;
        s.rdy = 1'b1;
        s.val = '0;
        s.tag = '0;
        if (int'(r) < N_REG) begin
            if (!stat_v[r])                                  s.val = rf[r];
            else if (win_valid && stat_tag[r] == win_idx)    s.val = bus_value;
            else begin
                s.rdy = 1'b0;
                s.tag = stat_tag[r];
            end
        end
        return s;
    endfunction

    // pick the lowest free station of the needed pool
    always_comb begin
        found     = 1'b0;
        alloc_idx = '0;
        for (int i = 0; i < N_RS; i++) begin
            if (!found && !busy[i] && pool_of_rs(i) == pool_of_op(op_e'(in_op))) begin
                found     = 1'b1;
                alloc_idx = TAG_W'(i);
            end
        end
        src_j = lookup(in_rs);
        src_k = lookup(in_rt);
    end

    assign in_ready = found;
    assign accept   = in_valid && found;

    // register file, tag table, cycle and sequence counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N_REG; r++) begin
                rf[r]       <= DATA_W'(r);
                stat_tag[r] <= '0;
            end
            stat_v <= '0;
            cyc_q  <= CYC_W'(1);
            seq_q  <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (win_valid && int'(bus_rd) < N_REG && stat_v[bus_rd] && stat_tag[bus_rd] == win_idx) begin
                rf[bus_rd]     <= bus_value;
                stat_v[bus_rd] <= 1'b0;
            end
            if (accept) begin
                seq_q <= seq_q + 1'b1;
                if (int'(in_rd) < N_REG) begin
                    stat_v[in_rd]   <= 1'b1;
                    stat_tag[in_rd] <= alloc_idx;
                end
            end
        end
    end

    for (genvar g = 0; g < N_RS; g++) begin : g_rs
        localparam int LAT = (g < N_ADD) ? LAT_ADD : (g < N_ADD + N_MUL) ? LAT_MUL : LAT_DIV;
        assign alloc[g] = accept && alloc_idx == TAG_W'(g);
        assign grant[g] = win_valid && win_idx == TAG_W'(g);
        rs_station #(
            .LAT(LAT), .DATA_W(DATA_W), .TAG_W(TAG_W),
            .SEQ_W(SEQ_W), .CYC_W(CYC_W), .RIDX_W(RIDX_W)
        ) u_rs (
            .clk(clk), .rst_n(rst_n), .cyc_i(cyc_q),
            .alloc_i(alloc[g]), .op_i(op_e'(in_op)), .seq_i(seq_q), .rd_i(in_rd),
            .j_rdy_i(src_j.rdy), .j_val_i(src_j.val), .j_tag_i(src_j.tag),
            .k_rdy_i(src_k.rdy), .k_val_i(src_k.val), .k_tag_i(src_k.tag),
            .bus_valid_i(win_valid), .bus_tag_i(win_idx), .bus_value_i(bus_value),
            .grant_i(grant[g]),
            .busy_o(busy[g]), .req_o(req[g]), .op_o(rs_op[g]), .seq_o(rs_seq[g]),
            .rd_o(rs_rd[g]), .res_o(rs_res[g]),
            .t_iss_o(rs_tiss[g]), .t_st_o(rs_tst[g]), .t_end_o(rs_tend[g])
        );
    end

    wb_arbiter #(.N(N_RS), .SEQ_W(SEQ_W), .IDX_W(TAG_W)) u_arb (
        .req_i(req), .seq_i(rs_seq), .win_valid_o(win_valid), .win_idx_o(win_idx)
    );

    assign wb_valid   = win_valid;
    assign wb_seq     = rs_seq[win_idx];
    assign wb_op      = rs_op[win_idx];
    assign wb_rd      = bus_rd;
    assign wb_value   = bus_value;
    assign wb_t_issue = rs_tiss[win_idx];
    assign wb_t_start = rs_tst[win_idx];
    assign wb_t_end   = rs_tend[win_idx];
    assign cyc_now    = cyc_q;
    assign rf_data    = (int'(rf_addr) < N_REG) ? rf[rf_addr] : '0;

endmodule

// File: rtl/tomasulo_core_chk.sv
module tomasulo_core_chk #(
    parameter int N_RS    = 9,
    parameter int LAT_ADD = 4,
    parameter int LAT_MUL = 12,
    parameter int LAT_DIV = 38,
    parameter int SEQ_W   = 8,
    parameter int CYC_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_RS-1:0]  grant,
    input logic             wb_valid,
    input logic [SEQ_W-1:0] wb_seq,
    input logic [1:0]       wb_op,
    input logic [CYC_W-1:0] wb_t_issue,
    input logic [CYC_W-1:0] wb_t_start,
    input logic [CYC_W-1:0] wb_t_end,
    input logic [CYC_W-1:0] cyc_now
);

    function automatic logic [CYC_W-1:0] span(logic [1:0] op);
        unique case (op)
            2'd0, 2'd1: return CYC_W'(LAT_ADD - 1);
            2'd2:       return CYC_W'(LAT_MUL - 1);
            default:    return CYC_W'(LAT_DIV - 1);
        endcase
    endfunction

    logic signed [CYC_W-1:0] gap_wb, gap_start;
    assign gap_wb    = cyc_now - wb_t_end;
    assign gap_start = wb_t_start - wb_t_issue;

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_wb_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> gap_wb > 0);

    assert_start_after_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> gap_start > 0);

    assert_exec_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_t_end - wb_t_start) == span(wb_op));

    assert_one_broadcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid)) |-> wb_seq != $past(wb_seq));

endmodule

bind tomasulo_core tomasulo_core_chk #(
    .N_RS(N_RS), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV),
    .SEQ_W(SEQ_W), .CYC_W(CYC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .wb_valid(wb_valid), .wb_seq(wb_seq),
    .wb_op(wb_op), .wb_t_issue(wb_t_issue), .wb_t_start(wb_t_start),
    .wb_t_end(wb_t_end), .cyc_now(cyc_now)
);

// File: tb/tomasulo_core_test.sv
module tomasulo_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [3:0]  in_rd = '0, in_rs = '0, in_rt = '0;
    logic        wb_valid;
    logic [7:0]  wb_seq;
    logic [1:0]  wb_op;
    logic [3:0]  wb_rd;
    logic [31:0] wb_value;
    logic [15:0] wb_t_issue, wb_t_start, wb_t_end, cyc_now;
    logic [3:0]  rf_addr = '0;
    logic [31:0] rf_data;

    always #10ns clk = ~clk;

    tomasulo_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt),
        .wb_valid(wb_valid), .wb_seq(wb_seq), .wb_op(wb_op), .wb_rd(wb_rd),
        .wb_value(wb_value), .wb_t_issue(wb_t_issue), .wb_t_start(wb_t_start),
        .wb_t_end(wb_t_end), .cyc_now(cyc_now), .rf_addr(rf_addr), .rf_data(rf_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // program under test
    int n;
    int p_op[16], p_rd[16], p_rs[16], p_rt[16];
    // behavioural model results
    int m_iss[16], m_xs[16], m_xe[16], m_wb[16], m_val[16], m_b[16], m_pj[16], m_pk[16];
    int last_wb;

    task automatic put(input int op, input int rd, input int rs, input int rt);
        p_op[n] = op; p_rd[n] = rd; p_rs[n] = rs; p_rt[n] = rt;
        n++;
    endtask

    function automatic int pool(input int op);
        return (op < 2) ? 0 : (op == 2) ? 1 : 2;
    endfunction

    function automatic int lat(input int op);
        return (op < 2) ? 4 : (op == 2) ? 12 : 38;
    endfunction

    function automatic int calc(input int op, input int a, input int b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a * b;
            default: return (b == 0) ? 0 : a / b;
        endcase
    endfunction

    function automatic bit avail(input int p, input int c);
        return p < 0 || (m_wb[p] != 0 && m_wb[p] < c);
    endfunction

    task automatic build_model();
        int cap[3];
        int nxt;
        cap[0] = 4; cap[1] = 2; cap[2] = 3;
        nxt = 0;
        last_wb = 0;
        for (int i = 0; i < 16; i++) begin
            m_iss[i] = 0; m_xs[i] = 0; m_xe[i] = 0; m_wb[i] = 0;
            m_val[i] = 0; m_b[i] = 0; m_pj[i] = -1; m_pk[i] = -1;
        end
        for (int c = 1; c < 2000; c++) begin
            int best;
            int used;
            best = -1;
            for (int i = 0; i < nxt; i++)
                if (best < 0 && m_xe[i] != 0 && m_xe[i] < c && m_wb[i] == 0) best = i;
            if (best >= 0) begin
                m_wb[best] = c;
                last_wb = c;
            end
            for (int i = 0; i < nxt; i++) begin
                if (m_xs[i] == 0 && m_iss[i] < c && avail(m_pj[i], c) && avail(m_pk[i], c)) begin
                    int a, b;
                    a = (m_pj[i] < 0) ? p_rs[i] : m_val[m_pj[i]];
                    b = (m_pk[i] < 0) ? p_rt[i] : m_val[m_pk[i]];
                    m_b[i]   = b;
                    m_val[i] = calc(p_op[i], a, b);
                    m_xs[i]  = c;
                    m_xe[i]  = c + lat(p_op[i]) - 1;
                end
            end
            if (nxt < n) begin
                used = 0;
                for (int i = 0; i < nxt; i++)
                    if (pool(p_op[i]) == pool(p_op[nxt]) && (m_wb[i] == 0 || m_wb[i] >= c)) used++;
                if (used < cap[pool(p_op[nxt])]) begin
                    m_iss[nxt] = c;
                    for (int i = 0; i < nxt; i++) begin
                        if (p_rd[i] == p_rs[nxt]) m_pj[nxt] = i;
                        if (p_rd[i] == p_rt[nxt]) m_pk[nxt] = i;
                    end
                    nxt++;
                end
            end
            if (nxt == n && best < 0) begin
                bit all_done;
                all_done = 1'b1;
                for (int i = 0; i < n; i++) if (m_wb[i] == 0) all_done = 1'b0;
                if (all_done) break;
            end
        end
    endtask

    task automatic run_program(input string name);
        int k;
        int fin[13];
        build_model();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", {name, " wb_valid in reset"}, wb_valid, 0);
        check("R9", {name, " in_ready in reset"}, in_ready, 1);
        check("R9", {name, " cycle in reset"}, cyc_now, 1);
        for (int r = 0; r < 13; r++) begin
            rf_addr = 4'(r);
            #1ns;
            check("R9", $sformatf("%s reset F%0d", name, r), $signed(rf_data), r);
        end
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        for (int c = 1; c <= last_wb + 1; c++) begin
            int e;
            bit acc;
            if (k < n) begin
                in_valid = 1'b1;
                in_op = 2'(p_op[k]); in_rd = 4'(p_rd[k]);
                in_rs = 4'(p_rs[k]); in_rt = 4'(p_rt[k]);
            end else in_valid = 1'b0;
            #1ns;
            if (k < n)
                check("R5", $sformatf("%s in_ready inst %0d cycle %0d", name, k, c), in_ready, (m_iss[k] == c));
            e = -1;
            for (int i = 0; i < n; i++) if (m_wb[i] == c) e = i;
            check("R6", $sformatf("%s wb_valid cycle %0d", name, c), wb_valid, (e >= 0));
            if (e >= 0 && wb_valid) begin
                string vreq, sreq;
                vreq = (p_op[e] == 3 && m_b[e] == 0) ? "R8" : "R1";
                sreq = (m_pj[e] < 0 && m_pk[e] < 0) ? "R3" : "R4";
                check("R10", $sformatf("%s seq cycle %0d", name, c), wb_seq, e);
                check("R10", $sformatf("%s cyc_now inst %0d", name, e), cyc_now, c);
                check("R1", $sformatf("%s rd inst %0d", name, e), wb_rd, p_rd[e]);
                check(vreq, $sformatf("%s value inst %0d", name, e), $signed(wb_value), m_val[e]);
                check("R5", $sformatf("%s issue inst %0d", name, e), wb_t_issue, m_iss[e]);
                check(sreq, $sformatf("%s start inst %0d", name, e), wb_t_start, m_xs[e]);
                check("R2", $sformatf("%s end inst %0d", name, e), wb_t_end, m_xe[e]);
            end
            acc = in_valid && in_ready;
            @(posedge clk);
            if (acc) k++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int r = 0; r < 13; r++) fin[r] = r;
        for (int i = 0; i < n; i++) fin[p_rd[i]] = m_val[i];
        for (int r = 0; r < 13; r++) begin
            rf_addr = 4'(r);
            #1ns;
            check("R7", $sformatf("%s final F%0d", name, r), $signed(rf_data), fin[r]);
        end
    endtask

    initial begin
        // dependency chains and a full multiply pool
        n = 0;
        put(0, 1, 2, 3);  put(0, 4, 1, 5);  put(1, 6, 7, 8);  put(2, 9, 4, 10);
        put(3, 11, 12, 6); put(2, 8, 1, 5); put(2, 7, 2, 3);
        run_program("chain");

        // bus contention, divide by zero, write-after-write, add pool full
        n = 0;
        put(2, 1, 2, 3);  put(0, 4, 1, 2);  put(1, 5, 1, 3);  put(3, 6, 4, 0);
        put(0, 4, 2, 2);  put(0, 7, 4, 5);  put(0, 8, 2, 3);  put(2, 9, 8, 8);
        put(3, 10, 9, 5);
        run_program("contend");

        // operand bypass at issue, negative truncating divide
        n = 0;
        put(0, 1, 2, 3);  put(2, 4, 2, 2);  put(2, 5, 3, 3);  put(2, 6, 5, 1);
        put(3, 7, 6, 4);  put(1, 8, 0, 7);  put(3, 9, 8, 2);
        run_program("bypass");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule